// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a 64-bit watchdog counter behind a small register set that is reached over a simple word-addressed write/read port. Software first picks watchdog mode, sets a prescaler ratio and a 64-bit period, and then starts the counter. A prescaler divides the clock, and each time it wraps the 64-bit count advances by one.

Software arms the watchdog and later services it with the same two-write handshake. It writes a first 16-bit key and then a second, different key into the top half of the watchdog control word, and both writes have the enable bit set. A completed handshake clears the count and restarts the prescaler. If the armed count reaches the programmed period before the next service, the block raises a reset request for exactly one clock and sets a sticky timeout flag. After arming, software can neither disarm the watchdog nor change the timer setup.

Top module: `keyed_wdog`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, the watchdog is disarmed, and `wdog_rst` and `wdog_flag` are 0.
- R2: The word addresses are: 0 = count bits 31:0, 1 = count bits 63:32, 2 = period bits 31:0, 3 = period bits 63:32, 4 = global control, 5 = timer control, 6 = watchdog control. The count and period halves read back what was written. Global control reads back bits 1:0 (counter release), bits 3:2 (mode) and bits 11:8 (prescale minus one). Timer control reads back bits 23:22 (run mode).
- R3: The count advances only while global control bits 1:0 are 2'b11, global control bits 3:2 are 2 (watchdog) and timer control bits 23:22 are 2 (continuous). Under any other setting the count holds.
- R4: With prescale field value d, the count goes up by one every d+1 clocks while running.
- R5: A write of key 0xA5C6 in bits 31:16 with bit 14 set, followed by a write of key 0xDA7E with bit 14 set, arms the watchdog when the mode field is 2. Bit 14 of the watchdog control word reads 1 while armed. Outside watchdog mode the pair is ignored.
- R6: A completed key pair clears the 64-bit count and the prescaler in the clock that accepts the second key.
- R7: A watchdog control write that does not carry the expected next key with bit 14 set returns the key sequencer to idle and does not clear the count.
- R8: Once armed, writes to global control and timer control are ignored, and a watchdog control write with bit 14 clear does not disarm.
- R9: When an armed count steps to a value equal to the 64-bit period, `wdog_rst` is 1 for exactly one clock, starting in the cycle the count shows that value. An unarmed count never raises it.
- R10: `wdog_flag` is set together with `wdog_rst` and stays 1, even across services, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdog_rst | output | 1 | One-clock reset request on timeout |
| wdog_flag | output | 1 | Sticky timeout indicator |

## Verification
If the key sequencer holds the wrong state, the effect shows up as a count that fails to return to zero, or returns to zero when it should not. This is visible on a count read two clocks after the last key write. A fault in the lock or in the arm state shows at once in the control readback. A fault in the prescaler or in the compare only shows later, as a count that is off by a whole number of ticks. It can also show as a reset pulse in the wrong cycle or one that lasts too long. The bench therefore reads the count in cycles it has computed exactly, and samples the reset pulse in the cycle before it is due, the cycle it is due and the cycle after.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
// Shared constants for the key-protected watchdog: word addresses,
// key values, control field codes and the key sequencer state type.
package kwd_pkg;
    localparam logic [2:0] ADR_CNT_LO = 3'd0;
    localparam logic [2:0] ADR_CNT_HI = 3'd1;
    localparam logic [2:0] ADR_PRD_LO = 3'd2;
    localparam logic [2:0] ADR_PRD_HI = 3'd3;
    localparam logic [2:0] ADR_GCTL   = 3'd4;
    localparam logic [2:0] ADR_TCTL   = 3'd5;
    localparam logic [2:0] ADR_WCTL   = 3'd6;

    localparam int         KEY_W     = 16;
    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hA5C6;
    localparam logic [KEY_W-1:0] KEY_CLOSE = 16'hDA7E;
    localparam int         ARM_BIT   = 14;

    localparam logic [1:0] MODE_WDOG = 2'd2;
    localparam logic [1:0] RUN_CONT  = 2'd2;
    localparam int         DIV_LSB   = 8;
    localparam int         RUN_LSB   = 22;

    typedef enum logic {KS_IDLE, KS_OPENED} ks_state_e;
endpackage

// File: rtl/kwd_regs.sv
`timescale 1ns/1ps
// Control and period registers of the watchdog.
// Assumes: one write per clock; writes to global/timer control are
// dropped once the watchdog is armed; period registers stay writable.
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int PRE_W  = 4,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic              armed,
    output logic [1:0]        rel,
    output logic [1:0]        mode,
    output logic [PRE_W-1:0]  div,
    output logic [1:0]        run_mode,
    output logic [CNT_W-1:0]  prd,
    output logic              run
);
    // Register writes with the post-arm lock on the control words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel      <= '0;
            mode     <= '0;
            div      <= '0;
            run_mode <= '0;
            prd      <= '0;
        end else if (wr_en) begin
            case (addr)
                ADR_PRD_LO: prd[HALF_W-1:0]     <= wdata;
                ADR_PRD_HI: prd[CNT_W-1:HALF_W] <= wdata;
                ADR_GCTL: if (!armed) begin
                    rel  <= wdata[1:0];
                    mode <= wdata[3:2];
                    div  <= wdata[DIV_LSB +: PRE_W];
                end
                ADR_TCTL: if (!armed) run_mode <= wdata[RUN_LSB +: 2];
                default: ;
            endcase
        end
    end

    // Counting is allowed only with both halves released, watchdog mode and continuous run.
    always_comb run = (rel == 2'b11) && (mode == MODE_WDOG) && (run_mode == RUN_CONT);
endmodule

// File: rtl/kwd_keyseq.sv
`timescale 1ns/1ps
// Two-key sequencer: the opening key and then the closing key, each with
// the arm bit set, produce a one-clock service strobe and arm the watchdog.
// Assumes: wr is a single-cycle strobe for a watchdog control write.
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [KEY_W-1:0] key,
    input  logic             arm_bit,
    input  logic             wdog_mode,
    output logic             svc,
    output logic             armed
);
    ks_state_e state;
    logic      ok_open;
    logic      ok_close;

    // Decode whether this write carries the expected next key.
    always_comb begin
        ok_open  = wr && wdog_mode && arm_bit && (state == KS_IDLE)   && (key == KEY_OPEN);
        ok_close = wr && wdog_mode && arm_bit && (state == KS_OPENED) && (key == KEY_CLOSE);
        svc      = ok_close;
    end

    // Advance the sequencer; any other write returns it to idle. Arm is sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KS_IDLE;
            armed <= 1'b0;
        end else if (wr) begin
            state <= ok_open ? KS_OPENED : KS_IDLE;
            if (ok_close) armed <= 1'b1;
        end
    end
endmodule

// File: rtl/kwd_count.sv
`timescale 1ns/1ps
// Prescaler, 64-bit count and period compare with a one-shot timeout.
// Assumes: clr has priority over software writes, which have priority
// over counting; a timeout fires on the step that makes count == period.
module kwd_count #(
    parameter int HALF_W = 32,
    parameter int PRE_W  = 4,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRE_W-1:0]  div,
    input  logic              clr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic [CNT_W-1:0]  prd,
    input  logic              armed,
    output logic [CNT_W-1:0]  cnt,
    output logic              fire,
    output logic              flag
);
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] cnt_nxt;
    logic             tick;

    // Next count value and prescaler wrap.
    always_comb begin
        cnt_nxt = cnt + CNT_W'(1);
        tick    = run && (pre == div);
    end

    // Update prescaler, count, timeout pulse and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre  <= '0;
            cnt  <= '0;
            fire <= 1'b0;
            flag <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (clr) begin
                pre <= '0;
                cnt <= '0;
            end else if (wr_lo) begin
                cnt <= {cnt[CNT_W-1:HALF_W], wdata};
            end else if (wr_hi) begin
                cnt <= {wdata, cnt[HALF_W-1:0]};
            end else if (tick) begin
                pre <= '0;
                cnt <= cnt_nxt;
                if (armed && (cnt_nxt == prd)) begin
                    fire <= 1'b1;
                    flag <= 1'b1;
                end
            end else if (run) begin
                pre <= pre + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
// Key-protected 64-bit watchdog: register file, key sequencer and counter.
// Assumes: word-addressed single-cycle writes, combinational read data.
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              wdog_rst,
    output logic              wdog_flag
);
    localparam int CNT_W = 2 * HALF_W;

    logic [1:0]       rel;
    logic [1:0]       gmode;
    logic [PRE_W-1:0] div;
    logic [1:0]       run_mode;
    logic [CNT_W-1:0] prd;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic             armed;
    logic             svc;

    kwd_regs #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .armed(armed), .rel(rel), .mode(gmode),
        .div(div), .run_mode(run_mode), .prd(prd), .run(run)
    );

    kwd_keyseq u_keys (
        .clk(clk), .rst_n(rst_n),
        .wr(bus_wr && (bus_addr == ADR_WCTL)),
        .key(bus_wdata[HALF_W-1 -: KEY_W]), .arm_bit(bus_wdata[ARM_BIT]),
        .wdog_mode(gmode == MODE_WDOG), .svc(svc), .armed(armed)
    );

    kwd_count #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div), .clr(svc),
        .wr_lo(bus_wr && (bus_addr == ADR_CNT_LO)),
        .wr_hi(bus_wr && (bus_addr == ADR_CNT_HI)),
        .wdata(bus_wdata), .prd(prd), .armed(armed),
        .cnt(cnt), .fire(wdog_rst), .flag(wdog_flag)
    );

    // Read-back multiplexer; unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CNT_LO: bus_rdata = cnt[HALF_W-1:0];
            ADR_CNT_HI: bus_rdata = cnt[CNT_W-1:HALF_W];
            ADR_PRD_LO: bus_rdata = prd[HALF_W-1:0];
            ADR_PRD_HI: bus_rdata = prd[CNT_W-1:HALF_W];
            ADR_GCTL: begin
                bus_rdata[1:0]               = rel;
                bus_rdata[3:2]               = gmode;
                bus_rdata[DIV_LSB +: PRE_W]  = div;
            end
            ADR_TCTL: bus_rdata[RUN_LSB +: 2] = run_mode;
            ADR_WCTL: bus_rdata[ARM_BIT]      = armed;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwd_chk.sv
`timescale 1ns/1ps
// Property checker for keyed_wdog, attached with bind below.
// Assumes: synchronous active-low reset; observes internal arm/service state.
module kwd_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdog_rst,
    input logic             wdog_flag,
    input logic             armed,
    input logic             svc,
    input logic [1:0]       gmode,
    input logic [CNT_W-1:0] cnt
);
    a_r5_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
    a_r6_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> (cnt == '0));
    a_r8_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(gmode));
    a_r9_pulse_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);
    a_r9_pulse_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> $past(armed));
    a_r10_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> wdog_flag);
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_flag |=> wdog_flag);
endmodule

bind keyed_wdog kwd_chk #(.CNT_W(2 * HALF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wdog_rst(wdog_rst), .wdog_flag(wdog_flag),
    .armed(armed), .svc(svc), .gmode(gmode), .cnt(cnt)
);

// File: tb/keyed_wdog_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue expected items, a negedge monitor compares.
module keyed_wdog_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        wdog_rst;
    logic        wdog_flag;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          mon_req = 1'b0;
    bit          done = 1'b0;
    logic [31:0] exp_q[$];
    int          kind_q[$];
    string       tag_q[$];

    localparam logic [31:0] K_OPEN  = 32'hA5C6_4000;
    localparam logic [31:0] K_CLOSE = 32'hDA7E_4000;

    keyed_wdog u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_rst(wdog_rst), .wdog_flag(wdog_flag)
    );

    always #2.5 clk = ~clk;

    // Monitor: pop one expected item per requested sample and compare.
    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            logic [31:0] ev;
            logic [31:0] obs;
            int          k;
            string       t;
            ev = exp_q.pop_front();
            k  = kind_q.pop_front();
            t  = tag_q.pop_front();
            obs = (k == 0) ? bus_rdata : (k == 1) ? {31'd0, wdog_rst} : {31'd0, wdog_flag};
            n_chk++;
            if (obs !== ev) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", t, obs, ev);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [2:0] a,
                               input logic [31:0] v, input string tag);
        bus_addr = a;
        exp_q.push_back(v); kind_q.push_back(kind); tag_q.push_back(tag);
        mon_req = 1'b1;
        @(negedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] v, input string tag);
        expect_item(0, a, v, tag);
    endtask

    task automatic svc();
        wr(3'd6, K_OPEN);
        wr(3'd6, K_CLOSE);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: bench did not finish");
            summary();
            $finish;
        end
    end

    // Three-write key sequence checked against an un-cleared count of 3.
    task automatic seq3(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic [31:0] e, input string tag);
        svc();
        wr(3'd6, a); wr(3'd6, b); wr(3'd6, c);
        rd(3'd0, e, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd4, 32'h0, "R1 gctl");
        rd(3'd0, 32'h0, "R1 count");
        rd(3'd6, 32'h0, "R1 wctl");
        expect_item(1, 3'd0, 32'h0, "R1 rst pulse");
        expect_item(2, 3'd0, 32'h0, "R1 flag");
        // R2 readback
        wr(3'd2, 32'h1234_5678); wr(3'd3, 32'h9ABC_DEF0);
        rd(3'd2, 32'h1234_5678, "R2 prd lo");
        rd(3'd3, 32'h9ABC_DEF0, "R2 prd hi");
        wr(3'd0, 32'h55); wr(3'd1, 32'h2);
        rd(3'd0, 32'h55, "R2 cnt lo");
        rd(3'd1, 32'h2, "R2 cnt hi");
        // R5 key pair ignored outside watchdog mode
        wr(3'd4, 32'h0000_0103);
        svc();
        rd(3'd6, 32'h0, "R5 no arm in mode 0");
        rd(3'd0, 32'h55, "R5 no clear in mode 0");
        // R3 holds without continuous run mode
        wr(3'd4, 32'h0000_010B);
        rd(3'd4, 32'h0000_010B, "R2 gctl");
        repeat (10) @(posedge clk); #1;
        rd(3'd0, 32'h55, "R3 hold run mode 0");
        wr(3'd5, 32'h0040_0000);
        rd(3'd5, 32'h0040_0000, "R2 tctl");
        repeat (10) @(posedge clk); #1;
        rd(3'd0, 32'h55, "R3 hold run mode 1");
        // R4 prescaler divide by 2, unarmed past period (R9)
        wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h4); wr(3'd3, 32'h0);
        wr(3'd5, 32'h0080_0000);
        repeat (20) @(posedge clk); #1;
        rd(3'd0, 32'd10, "R4 count after 20 clocks");
        expect_item(2, 3'd0, 32'h0, "R9 no timeout while unarmed");
        // R5/R6 arm and service
        wr(3'd2, 32'h1000);
        svc();
        rd(3'd0, 32'h0, "R6 cleared by key pair");
        repeat (6) @(posedge clk); #1;
        rd(3'd0, 32'd3, "R6 prescaler restarted");
        rd(3'd6, 32'h0000_4000, "R5 armed");
        // R8 lock
        wr(3'd4, 32'h0);
        rd(3'd4, 32'h0000_010B, "R8 gctl locked");
        wr(3'd5, 32'h0);
        rd(3'd5, 32'h0080_0000, "R8 tctl locked");
        wr(3'd6, 32'h0);
        rd(3'd6, 32'h0000_4000, "R8 arm bit kept");
        // R7 invalid sequences do not clear
        seq3(K_OPEN, 32'h1234_4000, K_CLOSE, 32'd3, "R7 wrong key between");
        seq3(K_OPEN, K_OPEN, K_CLOSE, 32'd3, "R7 repeated first key");
        seq3(32'hA5C6_0000, K_CLOSE, K_CLOSE, 32'd3, "R7 arm bit clear");
        seq3(32'h1234_4000, K_OPEN, K_CLOSE, 32'd0, "R6 pair after junk clears");
        // R9 timeout at period 8, divide by 2
        svc();
        wr(3'd2, 32'h8);
        svc();
        repeat (14) @(posedge clk); #1;
        expect_item(2, 3'd0, 32'h0, "R9 flag before timeout");
        @(posedge clk); #1;
        expect_item(1, 3'd0, 32'h0, "R9 no pulse one cycle early");
        @(posedge clk); #1;
        expect_item(1, 3'd0, 32'h1, "R9 pulse at period");
        @(posedge clk); #1;
        expect_item(1, 3'd0, 32'h0, "R9 pulse lasts one clock");
        expect_item(2, 3'd0, 32'h1, "R10 flag set");
        // R10 sticky across service, cleared by reset
        svc();
        expect_item(2, 3'd0, 32'h1, "R10 flag survives service");
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        rst_n = 1'b1;
        expect_item(2, 3'd0, 32'h0, "R10 flag cleared by reset");
        rd(3'd6, 32'h0, "R1 disarmed by reset");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule